// File: doc/BRIEF.md
# Event-Reloaded System Watchdog

This block is a system watchdog. Its countdown is programmed in seconds. Software restarts it by writing the timeout register. Two peripheral interrupt lines, one from a pointing device and one from a keyboard, can also reload the countdown, and each line has its own enable. When the count runs out, a status flag is set. The same flag can be set at once in two other ways: by writing a self-clearing force bit, or by a filtered rising edge on a keyboard-reset line. A power LED output can blink at 1 Hz with an even duty cycle. The blink is either requested directly or tied to the timeout flag.

Time comes from a one-cycle tick input that pulses at 1 MHz. `TICKS_PER_SEC` of these ticks make one countdown second. Half that number of ticks make one LED phase. The keyboard-reset line is synchronised first. It must then stay at its new level for `DEB_CYCLES` clock cycles, which is one microsecond at the default clock, before its edge is accepted. The interrupt lines are synchronous to `clk` and are rising-edge detected.

The control logic is one state machine with three states. ST_IDLE means counting is disabled. ST_COUNT means the countdown is running. ST_EXPIRED means the timeout flag is set. The transitions are:
- IDLE→COUNT on a non-zero timeout write.
- COUNT→COUNT (reload) on an enabled interrupt edge or on a new non-zero timeout write.
- COUNT→IDLE on a zero timeout write.
- COUNT→EXPIRED when the count reaches zero.
- Any state→EXPIRED on a force, an accepted reset edge, or a software write of 1 to the flag.
- EXPIRED→COUNT or EXPIRED→IDLE when software writes 0 to the flag. The new state depends on whether the timeout register is non-zero.

Top module: `wdog_evt_reload`

## Requirements
- R1: After reset, all three registers read 0x00, `wdt_status` is 0 and `pwr_led` is 0.
- R2: The register at address 0 holds bits 3..1 as read/write. Bit 3 enables LED blink on timeout, bit 2 enables mouse reload and bit 1 enables keyboard reload. Bits 7..4 and bit 0 read 0.
- R3: The register at address 1 reads {0000, reset-edge enable (bit 3), 0 (bit 2), blink enable (bit 1), status (bit 0)}. Bit 2 always reads 0.
- R4: The register at address 2 reads back as written. A non-zero write loads the countdown. The count drops by one every `TICKS_PER_SEC` ticks, and the status flag sets when it reaches zero.
- R5: Writing 0 to address 2 disables counting, and the status flag stays 0.
- R6: With address-0 bit 2 set, a rising edge on `mouse_irq` reloads the countdown from address 2. With that bit clear, the edge has no effect.
- R7: With address-0 bit 1 set, a rising edge on `kbd_irq` reloads the countdown. With that bit clear, the edge has no effect.
- R8: While the status flag is 1, interrupt edges have no effect and the flag stays 1.
- R9: Writing 1 to address-1 bit 2 sets the status flag on the next cycle. The bit itself clears at once.
- R10: With address-1 bit 3 set, a `kbd_rst_in` pulse that lasts at least `DEB_CYCLES` cycles sets the status flag. A shorter pulse is rejected. With bit 3 clear, the line has no effect.
- R11: Software writes address-1 bit 0 directly. Writing 0 while the flag is set restarts the countdown from address 2.
- R12: With address-1 bit 1 set, `pwr_led` starts low. It then toggles every `TICKS_PER_SEC/2` ticks, giving a 50% duty cycle.
- R13: With address-0 bit 3 set and the status flag at 1, `pwr_led` blinks in the same way.
- R14: When neither blink source is active, `pwr_led` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse at 1 MHz |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0, 1, 2) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| mouse_irq | input | 1 | Mouse interrupt, synchronous |
| kbd_irq | input | 1 | Keyboard interrupt, synchronous |
| kbd_rst_in | input | 1 | Keyboard reset line, asynchronous |
| wdt_status | output | 1 | Timeout flag |
| pwr_led | output | 1 | Power LED drive |

## Verification
A wrong state shows up at `wdt_status` and `reg_rdata` bit 0 exactly one cycle after the event that should have changed it. A machine stuck in ST_COUNT or ST_IDLE shows up as a flag that never rises within one second of the programmed timeout. A reload that was lost or taken by mistake moves the rise of the flag by a whole number of seconds. The directed tests therefore sample a few cycles on each side of the expected expiry. A wrong blinker divider shows up within one LED phase, as a wrong count of high cycles over several periods.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } wd_state_e;

    localparam logic [1:0] ADDR_CTRL0 = 2'd0;
    localparam logic [1:0] ADDR_CTRL1 = 2'd1;
    localparam logic [1:0] ADDR_TMO   = 2'd2;

    // address 0 fields
    localparam int C0_LED_ON_TMO = 3;
    localparam int C0_MOUSE_EN   = 2;
    localparam int C0_KBD_EN     = 1;
    // address 1 fields
    localparam int C1_RST_EN     = 3;
    localparam int C1_FORCE      = 2;
    localparam int C1_BLINK      = 1;
    localparam int C1_STATUS     = 0;
endpackage

// File: rtl/wdog_debounce.sv
module wdog_debounce #(
    parameter int DEB_CYCLES = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic rise_o
);
    localparam int DW = $clog2(DEB_CYCLES + 1);
    localparam logic [DW-1:0] DEB_LAST = DW'(DEB_CYCLES - 1);

    logic meta_q, sync_q, filt_q;
    logic [DW-1:0] run_q;
    logic flip;

    assign flip   = (sync_q != filt_q) && (run_q == DEB_LAST);
    assign rise_o = flip && sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            filt_q <= 1'b0;
            run_q  <= '0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
            if (sync_q == filt_q) begin
                run_q <= '0;
            end else if (flip) begin
                filt_q <= sync_q;
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R10: the filtered level never moves while it agrees with the input
    assert_filter_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q == filt_q) |=> $stable(filt_q));
    assert_rise_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> filt_q);
endmodule

// File: rtl/wdog_blinker.sv
module wdog_blinker #(
    parameter int TICKS_PER_SEC = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic en_i,
    output logic led_o
);
    localparam int HALF = TICKS_PER_SEC / 2;
    localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF - 1);

    logic [HW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            led_o <= 1'b0;
        end else if (!en_i) begin
            div_q <= '0;
            led_o <= 1'b0;
        end else if (tick_i) begin
            if (div_q == HALF_LAST) begin
                div_q <= '0;
                led_o <= ~led_o;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assert_led_off_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !led_o);
    assert_led_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i) |=> $stable(led_o));
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000000,
    parameter int CNT_W         = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             tmo_wr_i,
    input  logic [CNT_W-1:0] tmo_wdata_i,
    input  logic [CNT_W-1:0] tmo_reg_i,
    input  logic             sts_wr_i,
    input  logic             sts_wdata_i,
    input  logic             set_evt_i,
    input  logic             reload_evt_i,
    output logic             status_o
);
    localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_SEC - 1);

    wd_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, load_val;
    logic [PW-1:0]    pre_q;
    logic sec_tick, load_cnt;

    assign sec_tick = tick_i && (state_q == ST_COUNT) && (pre_q == PRE_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (set_evt_i) begin
            state_d = ST_EXPIRED;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sts_wr_i && sts_wdata_i)                 state_d = ST_EXPIRED;
                    else if (tmo_wr_i && tmo_wdata_i != '0)      state_d = ST_COUNT;
                end
                ST_COUNT: begin
                    if (sts_wr_i && sts_wdata_i)                 state_d = ST_EXPIRED;
                    else if (tmo_wr_i)                           state_d = (tmo_wdata_i != '0) ? ST_COUNT : ST_IDLE;
                    else if (reload_evt_i)                       state_d = ST_COUNT;
                    else if (sec_tick && cnt_q == CNT_W'(1))     state_d = ST_EXPIRED;
                end
                ST_EXPIRED: begin
                    if (sts_wr_i && !sts_wdata_i)                state_d = (tmo_reg_i != '0) ? ST_COUNT : ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        status_o = (state_q == ST_EXPIRED);
        load_cnt = (state_d == ST_COUNT) &&
                   ((state_q != ST_COUNT) || tmo_wr_i || reload_evt_i);
        load_val = tmo_wr_i ? tmo_wdata_i : tmo_reg_i;
    end

    // countdown and second prescaler
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (load_cnt) begin
            cnt_q <= load_val;
            pre_q <= '0;
        end else if (state_q == ST_COUNT && tick_i) begin
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
            if (sec_tick) cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load_cnt) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    assert_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && cnt_q == CNT_W'(1) && !tmo_wr_i && !reload_evt_i && !sts_wr_i) |=> status_o);
    assert_set_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt_i |=> status_o);
    assert_no_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !(sts_wr_i && !sts_wdata_i)) |=> status_o);
    assert_zero_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_wr_i && tmo_wdata_i == '0 && !status_o && !set_evt_i) |=> !status_o);
endmodule

// File: rtl/wdog_evt_reload.sv
module wdog_evt_reload
    import wdog_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000000,
    parameter int DEB_CYCLES    = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       mouse_irq,
    input  logic       kbd_irq,
    input  logic       kbd_rst_in,
    output logic       wdt_status,
    output logic       pwr_led
);
    localparam int CNT_W = 8;

    logic [3:1] c0_q;
    logic       rst_en_q, blink_q;
    logic [CNT_W-1:0] tmo_q;
    logic [1:0] irq_in, irq_prev, irq_rise;
    logic wr_c0, wr_c1, wr_tmo, force_wr, kbd_rst_rise, set_evt, reload_evt, blink_en;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata[7:4];
    assign wr_c0    = reg_we && (reg_addr == ADDR_CTRL0);
    assign wr_c1    = reg_we && (reg_addr == ADDR_CTRL1);
    assign wr_tmo   = reg_we && (reg_addr == ADDR_TMO);
    assign force_wr = wr_c1 && reg_wdata[C1_FORCE];

    assign irq_in     = {mouse_irq, kbd_irq};
    assign irq_rise   = irq_in & ~irq_prev;
    assign reload_evt = (irq_rise[1] && c0_q[C0_MOUSE_EN]) || (irq_rise[0] && c0_q[C0_KBD_EN]);
    assign set_evt    = force_wr || (kbd_rst_rise && rst_en_q);
    assign blink_en   = blink_q || (c0_q[C0_LED_ON_TMO] && wdt_status);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c0_q     <= '0;
            rst_en_q <= 1'b0;
            blink_q  <= 1'b0;
            tmo_q    <= '0;
            irq_prev <= '0;
        end else begin
            irq_prev <= irq_in;
            if (wr_c0)  c0_q <= reg_wdata[3:1];
            if (wr_c1) begin
                rst_en_q <= reg_wdata[C1_RST_EN];
                blink_q  <= reg_wdata[C1_BLINK];
            end
            if (wr_tmo) tmo_q <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL0: reg_rdata[3:1] = c0_q;
            ADDR_CTRL1: reg_rdata = {4'b0000, rst_en_q, 1'b0, blink_q, wdt_status};
            ADDR_TMO:   reg_rdata = tmo_q;
            default:    reg_rdata = '0;
        endcase
    end

    wdog_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk(clk), .rst_n(rst_n), .raw_i(kbd_rst_in), .rise_o(kbd_rst_rise)
    );

    wdog_core #(.TICKS_PER_SEC(TICKS_PER_SEC), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_us),
        .tmo_wr_i(wr_tmo), .tmo_wdata_i(reg_wdata), .tmo_reg_i(tmo_q),
        .sts_wr_i(wr_c1), .sts_wdata_i(reg_wdata[C1_STATUS]),
        .set_evt_i(set_evt), .reload_evt_i(reload_evt), .status_o(wdt_status)
    );

    wdog_blinker #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_blink (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_us), .en_i(blink_en), .led_o(pwr_led)
    );

    assert_force_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        force_wr |=> wdt_status);
    assert_ctrl1_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_CTRL1) |-> (reg_rdata[7:4] == 4'h0 && !reg_rdata[2]));
    assert_ctrl0_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_CTRL0) |-> (reg_rdata[7:4] == 4'h0 && !reg_rdata[0]));
endmodule

// File: tb/tb_wdog_evt_reload.sv
module tb_wdog_evt_reload;
    localparam int TPS = 10;
    localparam int DEB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic mouse_irq = 1'b0, kbd_irq = 1'b0, kbd_rst_in = 1'b0;
    logic wdt_status, pwr_led;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    initial forever begin
        @(negedge clk) tick_us = 1'b1;
        @(negedge clk) tick_us = 1'b0;
    end

    wdog_evt_reload #(.TICKS_PER_SEC(TPS), .DEB_CYCLES(DEB)) dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mouse_irq(mouse_irq), .kbd_irq(kbd_irq), .kbd_rst_in(kbd_rst_in),
        .wdt_status(wdt_status), .pwr_led(pwr_led)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_run++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk) reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic pulse_mouse();
        mouse_irq = 1'b1;
        @(negedge clk) mouse_irq = 1'b0;
    endtask

    task automatic pulse_kbd();
        kbd_irq = 1'b1;
        @(negedge clk) kbd_irq = 1'b0;
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1 if (pwr_led) h++;
        end
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        for (int a = 0; a < 3; a++) begin
            rd(2'(a), v);
            check("R1 register reset value", v, 0);
        end
        check("R1 status after reset", int'(wdt_status), 0);
        check("R1 led after reset", int'(pwr_led), 0);
    endtask

    task automatic t_regs();
        int v;
        do_reset();
        wr(2'd0, 8'hFF); rd(2'd0, v);
        check("R2 ctrl0 readback", v, 8'h0E);
        wr(2'd1, 8'hFF); rd(2'd1, v);
        check("R3 ctrl1 readback with force", v, 8'h0B);
        wr(2'd2, 8'hA5); rd(2'd2, v);
        check("R4 timeout readback", v, 8'hA5);
    endtask

    task automatic t_timeout();
        do_reset();
        wr(2'd2, 8'd3);
        wait_cyc(52); check("R4 status before expiry", int'(wdt_status), 0);
        wait_cyc(16); check("R4 status after expiry", int'(wdt_status), 1);
    endtask

    task automatic t_zero();
        do_reset();
        wr(2'd2, 8'd0);
        wait_cyc(200); check("R5 zero timeout never expires", int'(wdt_status), 0);
        wr(2'd2, 8'd3); wait_cyc(40); wr(2'd2, 8'd0);
        wait_cyc(80); check("R5 zero write stops countdown", int'(wdt_status), 0);
    endtask

    task automatic t_reload(input bit use_mouse, input bit enabled);
        do_reset();
        wr(2'd0, use_mouse ? (enabled ? 8'h04 : 8'h02) : (enabled ? 8'h02 : 8'h04));
        wr(2'd2, 8'd3);
        wait_cyc(40);
        if (use_mouse) pulse_mouse(); else pulse_kbd();
        wait_cyc(26);
        if (use_mouse) check("R6 mouse reload at old expiry", int'(wdt_status), enabled ? 0 : 1);
        else           check("R7 keyboard reload at old expiry", int'(wdt_status), enabled ? 0 : 1);
        wait_cyc(42);
        if (use_mouse) check("R6 expiry after mouse reload", int'(wdt_status), 1);
        else           check("R7 expiry after keyboard reload", int'(wdt_status), 1);
    endtask

    task automatic t_expired_and_clear();
        int v;
        do_reset();
        wr(2'd0, 8'h06);
        wr(2'd2, 8'd1);
        wait_cyc(30); check("R4 one-second timeout", int'(wdt_status), 1);
        pulse_mouse(); pulse_kbd(); wait_cyc(3);
        check("R8 interrupts ignored while expired", int'(wdt_status), 1);
        wr(2'd2, 8'd3);
        check("R8 timeout write keeps flag", int'(wdt_status), 1);
        wr(2'd1, 8'h00); rd(2'd1, v);
        check("R11 software clear", v, 0);
        wait_cyc(50); check("R11 restarted count running", int'(wdt_status), 0);
        wait_cyc(18); check("R11 restarted count expires", int'(wdt_status), 1);
        wr(2'd1, 8'h00); wr(2'd1, 8'h01);
        check("R11 software set", int'(wdt_status), 1);
    endtask

    task automatic t_force();
        int v;
        do_reset();
        wr(2'd1, 8'h04);
        check("R9 force sets status", int'(wdt_status), 1);
        rd(2'd1, v);
        check("R9 force bit reads zero", v, 8'h01);
    endtask

    task automatic t_kbd_rst();
        do_reset();
        wr(2'd1, 8'h08);
        kbd_rst_in = 1'b1; wait_cyc(DEB - 2); kbd_rst_in = 1'b0;
        wait_cyc(20); check("R10 short pulse rejected", int'(wdt_status), 0);
        kbd_rst_in = 1'b1; wait_cyc(DEB + 8); kbd_rst_in = 1'b0;
        wait_cyc(2); check("R10 long pulse sets status", int'(wdt_status), 1);
        do_reset();
        kbd_rst_in = 1'b1; wait_cyc(DEB + 8); kbd_rst_in = 1'b0;
        wait_cyc(10); check("R10 line ignored when disabled", int'(wdt_status), 0);
    endtask

    task automatic t_led();
        int h;
        do_reset();
        wr(2'd1, 8'h02);
        count_high(8, h); check("R12 blink starts low", h, 0);
        count_high(400, h);
        check("R12 duty near half", int'(h >= 190 && h <= 210), 1);
        do_reset();
        wr(2'd1, 8'h04);
        count_high(100, h); check("R14 timeout without blink enable", h, 0);
        wr(2'd0, 8'h08);
        count_high(400, h);
        check("R13 blink on timeout", int'(h >= 190 && h <= 210), 1);
        wr(2'd0, 8'h00); wait_cyc(1);
        count_high(100, h); check("R14 led off when disabled", h, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regs();
        t_timeout();
        t_zero();
        t_reload(1'b1, 1'b1);
        t_reload(1'b1, 1'b0);
        t_reload(1'b0, 1'b1);
        t_reload(1'b0, 1'b0);
        t_expired_and_clear();
        t_force();
        t_kbd_rst();
        t_led();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule